// File: doc/BRIEF.md
# Cache line lock manager

This block holds the per-line valid, data-lock and instruction-lock state of a small set-associative tag array (16 sets of 4 ways by default). A requester presents one operation at a time: an allocation that locks the chosen line, a stash allocation, or a snoop invalidation of a named way. One cycle after the block accepts it, the block answers with the way it used or with a refusal. The victim is always taken from the set's unlocked ways. An invalid way is preferred, and a per-set rotating pointer settles the remaining choice.

A small control register set lets software enable the cache, forbid stash allocation and start a sweep. The sweep is a self-clearing sequencer that visits one set per cycle and wipes data locks, instruction locks or both. While it runs, the block is busy and holds off every request. Two sticky flags record events for software: an allocate-with-lock that found its set fully locked, and a snoop that removed a lock.

Top module: `cache_lock_mgr`

## Requirements
- R1: After reset every line is invalid and unlocked, every set pointer is 0, enable, stash-disable, sweep select, both flags and busy read 0, req_ready is 1 and rsp_valid is 0.
- R2: Request kind 2'b00 is allocate-with-lock, 2'b01 is stash, 2'b10 is snoop and 2'b11 does nothing (no response, no change). An accepted allocate-with-lock answers on rsp_* in the following cycle. The victim is the first unlocked invalid way met when scanning from the set's pointer upward (wrapping); failing that, it is the first unlocked way in the same scan. The line becomes valid, with only the data lock set when req_ilock=0 or only the instruction lock set when req_ilock=1, and the set's pointer moves to victim+1.
- R3: An allocate-with-lock whose set has every way locked is refused (rsp_refused=1), changes no line and sets the overflow flag.
- R4: A stash miss (req_hit=0) allocates by the R2 victim rule, leaving the line valid with no lock bits. If every way is locked it is refused, and the overflow flag is not touched.
- R5: A stash hit (req_hit=1) is never refused. It answers with req_way, does not change that line's state, and ignores locks and the stash-disable bit.
- R6: While stash-disable is 1, every stash miss is refused and no line is allocated.
- R7: A write to the stash-disable bit takes effect only if the enable bit already holds 0; otherwise the bit keeps its value.
- R8: A snoop clears the valid and both lock bits of line (req_set, req_way) and answers with req_way. If that line held any lock, the snoop flag sets; a snoop of an unlocked line leaves the flag alone.
- R9: Each flag is sticky. A register write with 0 in its flag field clears it, and a 1 leaves it as it is. A hardware set in the same cycle as a clearing write wins.
- R10: Writing start=1 while the enable bit already holds 1 starts a sweep, and busy reads 1 from the next cycle. With enable at 0 the write has no effect. Writes to start and to the sweep select made while busy is 1 are ignored.
- R11: A sweep keeps busy at 1 for exactly SETS cycles and then drops it by itself. Select 2'b01 clears data locks, 2'b10 clears instruction locks, 2'b11 clears both and 2'b00 clears none. Valid bits stay as they are.
- R12: While busy is 1, req_ready is 0, no request is accepted and no response appears. A request held through the sweep is served after it ends and sees the swept state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_kind | input | 2 | Operation code (see R2) |
| req_set | input | IDXW | Target set |
| req_way | input | WAYW | Way for snoop or stash hit |
| req_hit | input | 1 | Stash write hits the resident line at req_way |
| req_ilock | input | 1 | Allocate-with-lock takes an instruction lock |
| rsp_valid | output | 1 | Response present |
| rsp_refused | output | 1 | Request was refused |
| rsp_way | output | WAYW | Way used |
| cfg_we | input | 1 | Control register write strobe |
| cfg_enable | input | 1 | Cache enable value to write |
| cfg_start | input | 1 | Sweep start value to write |
| cfg_sel | input | 2 | Sweep select value to write |
| cfg_stash_off | input | 1 | Stash-disable value to write |
| cfg_ovf_keep | input | 1 | 0 clears the overflow flag |
| cfg_snp_keep | input | 1 | 0 clears the snoop flag |
| st_enable | output | 1 | Enable bit |
| st_sel | output | 2 | Sweep select |
| st_stash_off | output | 1 | Stash-disable bit |
| st_ovf_flag | output | 1 | Overflow flag |
| st_snp_flag | output | 1 | Snoop lock-clear flag |
| busy | output | 1 | Sweep running; doubles as the start bit readback |
| look_set | input | IDXW | Set to read on the look port |
| look_valid | output | WAYS | Valid bits of look_set |
| look_dlock | output | WAYS | Data-lock bits of look_set |
| look_ilock | output | WAYS | Instruction-lock bits of look_set |

## Verification
Two things can land on a sticky flag in the same cycle: a hardware event that sets it (a refused allocate-with-lock, or a snoop of a locked line) and a software write that clears it. The bench drives the request and the clearing register write on the same clock edge, in both cases with the flag already set. The flag must read 1 afterwards and must drop on a later write made alone. A second overlap is a request raised in the cycle a sweep starts. The bench counts how many cycles req_ready stays low and checks that the late allocation sees the locks the sweep removed.

// File: rtl/clm_pkg.sv
package clm_pkg;

    typedef enum logic [1:0] {
        OP_LOCK_ALLOC = 2'b00,
        OP_STASH      = 2'b01,
        OP_SNOOP      = 2'b10,
        OP_IDLE       = 2'b11
    } op_kind_e;

    localparam int SEL_DATA_BIT = 0;
    localparam int SEL_INSN_BIT = 1;

endpackage

// File: rtl/clm_victim_pick.sv
module clm_victim_pick #(
    parameter  int WAYS = 4,
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] valid_i,
    input  logic [WAYS-1:0] locked_i,
    input  logic [WAYW-1:0] ptr_i,
    output logic            found_o,
    output logic [WAYW-1:0] way_o
);

    logic            inv_hit;
    logic            any_hit;
    logic [WAYW-1:0] inv_way;
    logic [WAYW-1:0] any_way;
    logic [WAYW-1:0] cand;

    // Scan from the pointer; lower offsets overwrite later, so the nearest wins.
    always_comb begin
        inv_hit = 1'b0;
        any_hit = 1'b0;
        inv_way = '0;
        any_way = '0;
        cand    = '0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            cand = ptr_i + WAYW'(k);
            if (!locked_i[cand]) begin
                any_hit = 1'b1;
                any_way = cand;
                if (!valid_i[cand]) begin
                    inv_hit = 1'b1;
                    inv_way = cand;
                end
            end
        end
        found_o = any_hit;
        way_o   = inv_hit ? inv_way : any_way;
    end

    always_comb begin
        assert (!found_o || !locked_i[way_o])
            else $error("assert_victim_unlocked_R2 failed");
    end

endmodule

// File: rtl/clm_flash_seq.sv
module clm_flash_seq #(
    parameter  int SETS = 16,
    localparam int IDXW = $clog2(SETS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    output logic            active_o,
    output logic [IDXW-1:0] idx_o
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(SETS - 1);

    typedef struct packed {
        logic            active;
        logic [IDXW-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.active) begin
            if (seq_q.idx == LAST_IDX) begin
                seq_d.active = 1'b0;
                seq_d.idx    = '0;
            end else begin
                seq_d.idx = seq_q.idx + IDXW'(1);
            end
        end else if (go_i) begin
            seq_d.active = 1'b1;
            seq_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign active_o = seq_q.active;
    assign idx_o    = seq_q.idx;

    assert_sweep_self_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.active && seq_q.idx == LAST_IDX) |=> !seq_q.active);

    assert_sweep_starts_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.active && go_i) |=> (seq_q.active && seq_q.idx == '0));

endmodule

// File: rtl/clm_ctl_regs.sv
module clm_ctl_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic       wr_enable_i,
    input  logic       wr_start_i,
    input  logic [1:0] wr_sel_i,
    input  logic       wr_stash_off_i,
    input  logic       wr_ovf_keep_i,
    input  logic       wr_snp_keep_i,
    input  logic       busy_i,
    input  logic       set_ovf_i,
    input  logic       set_snp_i,
    output logic       enable_o,
    output logic [1:0] sel_o,
    output logic       stash_off_o,
    output logic       ovf_o,
    output logic       snp_o,
    output logic       go_o
);

    typedef struct packed {
        logic       enable;
        logic [1:0] sel;
        logic       stash_off;
        logic       ovf;
        logic       snp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (we_i) begin
            ctl_d.enable = wr_enable_i;
            if (!ctl_q.enable) ctl_d.stash_off = wr_stash_off_i;
            if (!busy_i)       ctl_d.sel       = wr_sel_i;
        end
        // A hardware set beats a clearing write in the same cycle.
        ctl_d.ovf = set_ovf_i | (ctl_q.ovf & (!we_i | wr_ovf_keep_i));
        ctl_d.snp = set_snp_i | (ctl_q.snp & (!we_i | wr_snp_keep_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign go_o        = we_i && wr_start_i && ctl_q.enable && !busy_i;
    assign enable_o    = ctl_q.enable;
    assign sel_o       = ctl_q.sel;
    assign stash_off_o = ctl_q.stash_off;
    assign ovf_o       = ctl_q.ovf;
    assign snp_o       = ctl_q.snp;

    assert_stash_off_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && ctl_q.enable) |=> $stable(ctl_q.stash_off));

    assert_ovf_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovf_i |=> ctl_q.ovf);

    assert_snp_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_snp_i |=> ctl_q.snp);

    assert_sel_held_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(ctl_q.sel));

endmodule

// File: rtl/cache_lock_mgr.sv
module cache_lock_mgr #(
    parameter  int SETS = 16,
    parameter  int WAYS = 4,
    localparam int IDXW = $clog2(SETS),
    localparam int WAYW = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [IDXW-1:0] req_set,
    input  logic [WAYW-1:0] req_way,
    input  logic            req_hit,
    input  logic            req_ilock,
    output logic            rsp_valid,
    output logic            rsp_refused,
    output logic [WAYW-1:0] rsp_way,
    input  logic            cfg_we,
    input  logic            cfg_enable,
    input  logic            cfg_start,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_stash_off,
    input  logic            cfg_ovf_keep,
    input  logic            cfg_snp_keep,
    output logic            st_enable,
    output logic [1:0]      st_sel,
    output logic            st_stash_off,
    output logic            st_ovf_flag,
    output logic            st_snp_flag,
    output logic            busy,
    input  logic [IDXW-1:0] look_set,
    output logic [WAYS-1:0] look_valid,
    output logic [WAYS-1:0] look_dlock,
    output logic [WAYS-1:0] look_ilock
);

    import clm_pkg::*;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0] vld;
        logic [SETS-1:0][WAYS-1:0] dlk;
        logic [SETS-1:0][WAYS-1:0] ilk;
        logic [SETS-1:0][WAYW-1:0] ptr;
        logic                      rsp_v;
        logic                      rsp_ref;
        logic [WAYW-1:0]           rsp_way;
    } arr_t;

    arr_t st_d, st_q;

    logic            acc;
    logic            vic_found;
    logic [WAYW-1:0] vic_way;
    logic [WAYS-1:0] row_locked;
    logic            set_ovf;
    logic            set_snp;
    logic            go;
    logic            sw_active;
    logic [IDXW-1:0] sw_idx;
    logic [1:0]      sel;
    logic            stash_off;
    op_kind_e        kind;

    assign kind       = op_kind_e'(req_kind);
    assign acc        = req_valid && !sw_active;
    assign row_locked = st_q.dlk[req_set] | st_q.ilk[req_set];

    clm_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid_i  (st_q.vld[req_set]),
        .locked_i (row_locked),
        .ptr_i    (st_q.ptr[req_set]),
        .found_o  (vic_found),
        .way_o    (vic_way)
    );

    clm_flash_seq #(.SETS(SETS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go),
        .active_o (sw_active),
        .idx_o    (sw_idx)
    );

    clm_ctl_regs u_ctl (
        .clk            (clk),
        .rst_n          (rst_n),
        .we_i           (cfg_we),
        .wr_enable_i    (cfg_enable),
        .wr_start_i     (cfg_start),
        .wr_sel_i       (cfg_sel),
        .wr_stash_off_i (cfg_stash_off),
        .wr_ovf_keep_i  (cfg_ovf_keep),
        .wr_snp_keep_i  (cfg_snp_keep),
        .busy_i         (sw_active),
        .set_ovf_i      (set_ovf),
        .set_snp_i      (set_snp),
        .enable_o       (st_enable),
        .sel_o          (sel),
        .stash_off_o    (stash_off),
        .ovf_o          (st_ovf_flag),
        .snp_o          (st_snp_flag),
        .go_o           (go)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rsp_v   = 1'b0;
        st_d.rsp_ref = 1'b0;
        set_ovf      = 1'b0;
        set_snp      = 1'b0;

        if (sw_active) begin
            if (sel[SEL_DATA_BIT]) st_d.dlk[sw_idx] = '0;
            if (sel[SEL_INSN_BIT]) st_d.ilk[sw_idx] = '0;
        end

        if (acc) begin
            unique case (kind)
                OP_LOCK_ALLOC: begin
                    st_d.rsp_v = 1'b1;
                    if (vic_found) begin
                        st_d.vld[req_set][vic_way] = 1'b1;
                        st_d.dlk[req_set][vic_way] = !req_ilock;
                        st_d.ilk[req_set][vic_way] = req_ilock;
                        st_d.ptr[req_set]          = vic_way + WAYW'(1);
                        st_d.rsp_way               = vic_way;
                    end else begin
                        st_d.rsp_ref = 1'b1;
                        st_d.rsp_way = '0;
                        set_ovf      = 1'b1;
                    end
                end
                OP_STASH: begin
                    st_d.rsp_v = 1'b1;
                    if (req_hit) begin
                        st_d.rsp_way = req_way;
                    end else if (!stash_off && vic_found) begin
                        st_d.vld[req_set][vic_way] = 1'b1;
                        st_d.dlk[req_set][vic_way] = 1'b0;
                        st_d.ilk[req_set][vic_way] = 1'b0;
                        st_d.ptr[req_set]          = vic_way + WAYW'(1);
                        st_d.rsp_way               = vic_way;
                    end else begin
                        st_d.rsp_ref = 1'b1;
                        st_d.rsp_way = '0;
                    end
                end
                OP_SNOOP: begin
                    st_d.rsp_v   = 1'b1;
                    st_d.rsp_way = req_way;
                    set_snp      = row_locked[req_way];
                    st_d.vld[req_set][req_way] = 1'b0;
                    st_d.dlk[req_set][req_way] = 1'b0;
                    st_d.ilk[req_set][req_way] = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready    = !sw_active;
    assign busy         = sw_active;
    assign rsp_valid    = st_q.rsp_v;
    assign rsp_refused  = st_q.rsp_ref;
    assign rsp_way      = st_q.rsp_way;
    assign st_sel       = sel;
    assign st_stash_off = stash_off;
    assign look_valid   = st_q.vld[look_set];
    assign look_dlock   = st_q.dlk[look_set];
    assign look_ilock   = st_q.ilk[look_set];

    assert_snoop_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == OP_SNOOP) |=>
            (!st_q.vld[$past(req_set)][$past(req_way)] &&
             !st_q.dlk[$past(req_set)][$past(req_way)] &&
             !st_q.ilk[$past(req_set)][$past(req_way)]));

    assert_full_set_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == OP_LOCK_ALLOC && &row_locked) |=> (rsp_valid && rsp_refused && st_ovf_flag));

    assert_stash_off_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == OP_STASH && !req_hit && stash_off) |=> (rsp_valid && rsp_refused));

    assert_no_rsp_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_active && $past(sw_active)) |-> !rsp_valid);

    assert_disabled_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_start && !st_enable && !sw_active) |=> !sw_active);

endmodule

// File: tb/cache_lock_mgr_bench.sv
module cache_lock_mgr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'b00;
    logic [3:0] req_set = '0;
    logic [1:0] req_way = '0;
    logic       req_hit = 1'b0;
    logic       req_ilock = 1'b0;
    logic       rsp_valid;
    logic       rsp_refused;
    logic [1:0] rsp_way;
    logic       cfg_we = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_start = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic       cfg_stash_off = 1'b0;
    logic       cfg_ovf_keep = 1'b1;
    logic       cfg_snp_keep = 1'b1;
    logic       st_enable;
    logic [1:0] st_sel;
    logic       st_stash_off;
    logic       st_ovf_flag;
    logic       st_snp_flag;
    logic       busy;
    logic [3:0] look_set = '0;
    logic [3:0] look_valid;
    logic [3:0] look_dlock;
    logic [3:0] look_ilock;

    int total = 0;
    int bad   = 0;

    always #2.5ns clk = ~clk;

    cache_lock_mgr u_cache_lock_mgr (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_set(req_set), .req_way(req_way), .req_hit(req_hit), .req_ilock(req_ilock),
        .rsp_valid(rsp_valid), .rsp_refused(rsp_refused), .rsp_way(rsp_way),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_start(cfg_start), .cfg_sel(cfg_sel),
        .cfg_stash_off(cfg_stash_off), .cfg_ovf_keep(cfg_ovf_keep), .cfg_snp_keep(cfg_snp_keep),
        .st_enable(st_enable), .st_sel(st_sel), .st_stash_off(st_stash_off),
        .st_ovf_flag(st_ovf_flag), .st_snp_flag(st_snp_flag), .busy(busy),
        .look_set(look_set), .look_valid(look_valid), .look_dlock(look_dlock),
        .look_ilock(look_ilock)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic en, input logic st, input logic [1:0] sl,
                        input logic so, input logic ok, input logic sk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_enable = en; cfg_start = st; cfg_sel = sl;
        cfg_stash_off = so; cfg_ovf_keep = ok; cfg_snp_keep = sk;
        @(negedge clk);
        cfg_we = 1'b0; cfg_start = 1'b0; cfg_ovf_keep = 1'b1; cfg_snp_keep = 1'b1;
    endtask

    task automatic do_req(input logic [1:0] k, input logic [3:0] s, input logic [1:0] w,
                          input logic h, input logic il,
                          output logic rv, output logic rr, output logic [1:0] rw);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_set = s; req_way = w; req_hit = h; req_ilock = il;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        rv = rsp_valid; rr = rsp_refused; rw = rsp_way;
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic [1:0] k, input logic [3:0] s,
                              input logic [1:0] w, input logic h, input logic il,
                              input logic exp_ref, input logic [1:0] exp_way);
        logic rv, rr;
        logic [1:0] rw;
        do_req(k, s, w, h, il, rv, rr, rw);
        chk(req, {rv, rr, 2'b00, rw}, {1'b1, exp_ref, 2'b00, exp_way});
    endtask

    task automatic expect_set(input string req, input logic [3:0] s,
                              input logic [3:0] v, input logic [3:0] d, input logic [3:0] i);
        look_set = s;
        #1ns;
        chk(req, {look_valid, look_dlock, look_ilock}, {v, d, i});
    endtask

    task automatic sweep(input logic [1:0] sl, input logic poke, output int n);
        wcfg(1'b1, 1'b1, sl, 1'b0, 1'b1, 1'b1);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (poke && n == 2) begin
                cfg_we = 1'b1; cfg_enable = 1'b1; cfg_start = 1'b1; cfg_sel = ~sl;
            end else begin
                cfg_we = 1'b0; cfg_start = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; cfg_start = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", {st_enable, st_sel, st_stash_off, st_ovf_flag, st_snp_flag, busy},
            7'd0);
        chk("R1 handshake", {req_ready, rsp_valid}, 2'b10);
        expect_set("R1 set0 lines", 4'd0, 4'h0, 4'h0, 4'h0);
        expect_set("R1 set15 lines", 4'd15, 4'h0, 4'h0, 4'h0);
    endtask

    task automatic t_lock_fill;
        expect_rsp("R2 lock w0", 2'b00, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        expect_rsp("R2 lock w1", 2'b00, 4'd2, 2'd0, 1'b0, 1'b1, 1'b0, 2'd1);
        expect_rsp("R2 lock w2", 2'b00, 4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2);
        expect_rsp("R2 lock w3", 2'b00, 4'd2, 2'd0, 1'b0, 1'b1, 1'b0, 2'd3);
        expect_set("R2 set2 locks", 4'd2, 4'hF, 4'h5, 4'hA);
        expect_rsp("R3 refused", 2'b00, 4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
        chk("R3 overflow flag", st_ovf_flag, 1);
        expect_set("R3 lines unchanged", 4'd2, 4'hF, 4'h5, 4'hA);
    endtask

    task automatic t_stash_locked;
        wcfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R9 clear by zero", st_ovf_flag, 0);
        expect_rsp("R4 stash full refused", 2'b01, 4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
        chk("R4 no overflow flag", st_ovf_flag, 0);
        expect_rsp("R5 stash hit locked", 2'b01, 4'd2, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1);
        expect_set("R5 hit keeps line", 4'd2, 4'hF, 4'h5, 4'hA);
    endtask

    task automatic t_same_cycle_ovf;
        expect_rsp("R3 refused again", 2'b00, 4'd2, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_set = 4'd2; req_ilock = 1'b0;
        cfg_we = 1'b1; cfg_enable = 1'b0; cfg_start = 1'b0; cfg_sel = 2'b00;
        cfg_stash_off = 1'b0; cfg_ovf_keep = 1'b0; cfg_snp_keep = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0; cfg_ovf_keep = 1'b1;
        chk("R9 set beats clear ovf", st_ovf_flag, 1);
        wcfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        chk("R9 write one keeps", st_ovf_flag, 1);
        wcfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        chk("R9 cleared alone", st_ovf_flag, 0);
    endtask

    task automatic t_stash_rr;
        expect_rsp("R4 stash w0", 2'b01, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        expect_rsp("R4 stash w1", 2'b01, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1);
        expect_rsp("R4 stash w2", 2'b01, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2);
        expect_rsp("R4 stash w3", 2'b01, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3);
        expect_rsp("R2 rr wrap w0", 2'b01, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        expect_rsp("R2 rr next w1", 2'b01, 4'd5, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1);
        expect_set("R4 stash no locks", 4'd5, 4'hF, 4'h0, 4'h0);
    endtask

    task automatic t_mixed;
        expect_rsp("R2 set7 lock w0", 2'b00, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        expect_rsp("R2 set7 lock w1", 2'b00, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd1);
        expect_rsp("R4 set7 stash w2", 2'b01, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2);
        expect_rsp("R4 set7 stash w3", 2'b01, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd3);
        expect_rsp("R2 skip locked w2", 2'b01, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2);
        expect_rsp("R8 snoop unlocked", 2'b10, 4'd7, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2);
        chk("R8 flag stays clear", st_snp_flag, 0);
        expect_rsp("R2 invalid preferred", 2'b01, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd2);
        expect_rsp("R8 snoop locked", 2'b10, 4'd7, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        chk("R8 flag sets", st_snp_flag, 1);
        expect_set("R8 set7 state", 4'd7, 4'hE, 4'h2, 4'h0);
        wcfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
        chk("R9 snoop flag cleared", st_snp_flag, 0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b10; req_set = 4'd7; req_way = 2'd1;
        cfg_we = 1'b1; cfg_enable = 1'b0; cfg_start = 1'b0; cfg_sel = 2'b00;
        cfg_stash_off = 1'b0; cfg_ovf_keep = 1'b1; cfg_snp_keep = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0; cfg_snp_keep = 1'b1;
        chk("R9 set beats clear snoop", st_snp_flag, 1);
        expect_set("R8 set7 after second", 4'd7, 4'hC, 4'h0, 4'h0);
        wcfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_stash_off;
        wcfg(1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        wcfg(1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R7 write ignored when enabled", st_stash_off, 0);
        wcfg(1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R7 still ignored on disabling write", st_stash_off, 0);
        wcfg(1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1);
        chk("R7 taken when disabled", st_stash_off, 1);
        expect_rsp("R6 miss refused", 2'b01, 4'd9, 2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
        expect_set("R6 nothing allocated", 4'd9, 4'h0, 4'h0, 4'h0);
        expect_rsp("R5 hit with stash off", 2'b01, 4'd9, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2);
        wcfg(1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        chk("R7 cleared", st_stash_off, 0);
    endtask

    task automatic t_sweeps;
        int n;
        logic rv, rr;
        logic [1:0] rw;
        wcfg(1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b1);
        chk("R10 start ignored when disabled", busy, 0);
        expect_set("R10 no clear when disabled", 4'd2, 4'hF, 4'h5, 4'hA);
        wcfg(1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1);
        sweep(2'b01, 1'b1, n);
        chk("R11 busy cycles", n, 16);
        chk("R10 sel write ignored while busy", st_sel, 2'b01);
        expect_set("R11 data locks cleared", 4'd2, 4'hF, 4'h0, 4'hA);
        // R12: request raised in the first busy cycle waits out the sweep.
        wcfg(1'b1, 1'b1, 2'b10, 1'b0, 1'b1, 1'b1);
        req_valid = 1'b1; req_kind = 2'b00; req_set = 4'd2; req_ilock = 1'b1; req_hit = 1'b0;
        n = 0;
        while (!req_ready && n < 1000) begin
            chk("R12 no rsp while busy", rsp_valid, 0);
            n++;
            @(negedge clk);
        end
        @(negedge clk);
        rv = rsp_valid; rr = rsp_refused; rw = rsp_way;
        req_valid = 1'b0;
        chk("R12 stall cycles", n, 16);
        chk("R12 late request served", {rv, rr, 2'b00, rw}, {1'b1, 1'b0, 2'b00, 2'd0});
        expect_set("R11 insn cleared then locked", 4'd2, 4'hF, 4'h0, 4'h1);
        expect_rsp("R2 set3 data lock", 2'b00, 4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0);
        sweep(2'b00, 1'b0, n);
        chk("R11 sel none cycles", n, 16);
        expect_set("R11 sel none set2", 4'd2, 4'hF, 4'h0, 4'h1);
        expect_set("R11 sel none set3", 4'd3, 4'h1, 4'h1, 4'h0);
        sweep(2'b11, 1'b0, n);
        expect_set("R11 both set2", 4'd2, 4'hF, 4'h0, 4'h0);
        expect_set("R11 both set3", 4'd3, 4'h1, 4'h0, 4'h0);
        chk("R11 start self-cleared", busy, 0);
    endtask

    task automatic t_idle_kind;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b11; req_set = 4'd4;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 kind 11 no response", rsp_valid, 0);
        expect_set("R2 kind 11 no change", 4'd4, 4'h0, 4'h0, 4'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock_fill();
        t_stash_locked();
        t_same_cycle_ovf();
        t_stash_rr();
        t_mixed();
        t_stash_off();
        t_sweeps();
        t_idle_kind();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule